// File: doc/BRIEF.md
# Compact-encoding branch target unit

This block resolves every control-transfer instruction of a 16-bit instruction encoding in a single combinational step. It is handed the opcode under execution, the program counter as execution sees it (the instruction address plus 4, since fetch runs two halfwords ahead), the link register, one register operand and the four condition flags. From these it produces the taken decision, the address of the next instruction, the next link register value and the instruction-set mode bit. A taken branch raises a flush line for one cycle after the clock edge, so that the fetch stage can discard what it has already fetched.

Four kinds of transfer are handled. The first is the conditional short branch, with fourteen conditions and a signed 8-bit halfword offset. The second is the unconditional branch, with a signed 11-bit halfword offset. The third is the long call, which is split over two consecutive halves that carry a partial target through the link register. The fourth is the register branch with mode exchange, which takes the new mode from bit 0 of the target. Every other opcode passes through untouched: the next address is sequential and the link register is unchanged.

Top module: `hw16_branch_unit`

## Requirements
- R1: A conditional branch has opcode[15:12]=1101, its condition code in opcode[11:8] and a signed offset in opcode[7:0]. When the condition holds and exec_en is 1, taken is 1 and next_pc = pc_in + sign_extend(opcode[7:0])*2.
- R2: The condition codes are 0 EQ (Z), 1 NE (!Z), 2 CS (C), 3 CC (!C), 4 MI (N), 5 PL (!N), 6 VS (V), 7 VC (!V), 8 HI (C & !Z), 9 LS (!C | Z), 10 GE (N==V), 11 LT (N!=V), 12 GT (!Z & N==V) and 13 LE (Z | N!=V). flags is {N,Z,C,V}, with N at bit 3.
- R3: Whenever taken is 0, next_pc = pc_in - 2, which is the sequential next instruction. This covers a conditional branch whose condition fails.
- R4: Condition codes 14 and 15 under opcode[15:12]=1101 are not branches: taken is 0 and next_lr = lr_in.
- R5: An unconditional branch has opcode[15:11]=11100. It is always taken, with next_pc = pc_in + sign_extend(opcode[10:0])*2.
- R6: The first long-call half has opcode[15:11]=11110. It gives next_lr = pc_in + (sign_extend(opcode[10:0]) << 12) and does not branch.
- R7: The second long-call half has opcode[15:11]=11111. It is taken, with next_pc = lr_in + zero_extend(opcode[10:0])*2 and next_lr = pc_in - 1.
- R8: A branch-exchange has opcode[15:7]=010001110 and a register index in opcode[6:3]. It is taken, with narrow_mode = op_val[0] and next_pc = op_val with bit 0 cleared. When the index is 15 (the program counter), bit 1 is also cleared.
- R9: Any other opcode leaves taken 0, next_lr = lr_in and narrow_mode = 1.
- R10: taken is exec_en AND the branch decision, and flush equals the taken value of the previous clock cycle. A taken branch therefore gives a single-cycle flush pulse, and exec_en = 0 gives none.
- R11: While rst_n is 0, flush is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_en | input | 1 | The opcode is being executed this cycle |
| opcode | input | 16 | Instruction under execution |
| pc_in | input | ADDR_W | Program counter as seen in execute (instruction address + 4) |
| lr_in | input | ADDR_W | Current link register |
| op_val | input | ADDR_W | Value of the register named by opcode[6:3] |
| flags | input | 4 | Condition flags {N,Z,C,V} |
| taken | output | 1 | A branch is taken this cycle |
| next_pc | output | ADDR_W | Address of the next instruction |
| next_lr | output | ADDR_W | Next link register value |
| narrow_mode | output | 1 | 1 = stay in 16-bit encoding, 0 = switch to the wide encoding |
| flush | output | 1 | Registered one-cycle flush after a taken branch |

## Verification
The bench builds two copies side by side. One uses the default 32-bit address width. The other uses the minimum legal width of 24 bits, so that the long-call offset shifted left by 12 fills the datapath and its sign bit reaches the top. Both copies receive the same stimulus, and the narrow copy is checked against the 32-bit expectation truncated to 24 bits. This brings the wraparound of address arithmetic near zero and near the top of the address range within reach of the directed and random cases.

// File: rtl/hw16_br_pkg.sv
package hw16_br_pkg;

   localparam int OPC_W      = 16;
   localparam int COND_COUNT = 16;
   localparam int SEQ_STEP   = 2;
   localparam int LONG_SHIFT = 12;
   localparam int MIN_ADDR_W = 24;
   localparam logic [3:0] PC_REG_IDX = 4'd15;

   typedef enum logic [2:0] {
      BK_NONE,
      BK_COND,
      BK_JUMP,
      BK_CALL_HI,
      BK_CALL_LO,
      BK_EXCH
   } br_kind_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } flags_t;

   // Truth of one condition code; codes 14 and 15 never hold.
   function automatic logic cond_truth(input int code, input flags_t f);
      case (code)
         0:  return f.z;
         1:  return !f.z;
         2:  return f.c;
         3:  return !f.c;
         4:  return f.n;
         5:  return !f.n;
         6:  return f.v;
         7:  return !f.v;
         8:  return f.c && !f.z;
         9:  return !f.c || f.z;
         10: return f.n == f.v;
         11: return f.n != f.v;
         12: return !f.z && (f.n == f.v);
         13: return f.z || (f.n != f.v);
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/hw16_br_decode.sv
module hw16_br_decode
   import hw16_br_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   output br_kind_e         kind,
   output logic [3:0]       cond_code,
   output logic             src_is_pc
);

   always_comb begin
      kind = BK_NONE;
      if (opcode[15:12] == 4'b1101) begin
         if (opcode[11:9] != 3'b111) kind = BK_COND;
      end else if (opcode[15:11] == 5'b11100) begin
         kind = BK_JUMP;
      end else if (opcode[15:11] == 5'b11110) begin
         kind = BK_CALL_HI;
      end else if (opcode[15:11] == 5'b11111) begin
         kind = BK_CALL_LO;
      end else if (opcode[15:7] == 9'b010001110) begin
         kind = BK_EXCH;
      end
   end

   assign cond_code = opcode[11:8];
   assign src_is_pc = (opcode[6:3] == PC_REG_IDX);

endmodule

// File: rtl/hw16_br_cond.sv
module hw16_br_cond
   import hw16_br_pkg::*;
(
   input  flags_t     flags,
   input  logic [3:0] cond_code,
   output logic       hold
);

   logic [COND_COUNT-1:0] hold_vec;

   for (genvar c = 0; c < COND_COUNT; c++) begin : g_code
      assign hold_vec[c] = cond_truth(c, flags);
   end

   assign hold = hold_vec[cond_code];

endmodule

// File: rtl/hw16_br_offsets.sv
module hw16_br_offsets
   import hw16_br_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [OPC_W-1:0]  opcode,
   output logic [ADDR_W-1:0] off_short,
   output logic [ADDR_W-1:0] off_jump,
   output logic [ADDR_W-1:0] off_call_hi,
   output logic [ADDR_W-1:0] off_call_lo
);

   localparam int SHORT_PAD = ADDR_W - 9;
   localparam int JUMP_PAD  = ADDR_W - 12;
   localparam int HI_PAD    = ADDR_W - 11 - LONG_SHIFT;

   assign off_short   = {{SHORT_PAD{opcode[7]}}, opcode[7:0], 1'b0};
   assign off_jump    = {{JUMP_PAD{opcode[10]}}, opcode[10:0], 1'b0};
   assign off_call_lo = {{JUMP_PAD{1'b0}}, opcode[10:0], 1'b0};

   if (HI_PAD > 0) begin : g_hi_ext
      assign off_call_hi = {{HI_PAD{opcode[10]}}, opcode[10:0], {LONG_SHIFT{1'b0}}};
   end else begin : g_hi_fit
      assign off_call_hi = {opcode[10:0], {LONG_SHIFT{1'b0}}};
   end

endmodule

// File: rtl/hw16_branch_unit.sv
module hw16_branch_unit
   import hw16_br_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exec_en,
   input  logic [15:0]       opcode,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [ADDR_W-1:0] lr_in,
   input  logic [ADDR_W-1:0] op_val,
   input  logic [3:0]        flags,
   output logic              taken,
   output logic [ADDR_W-1:0] next_pc,
   output logic [ADDR_W-1:0] next_lr,
   output logic              narrow_mode,
   output logic              flush
);

   localparam logic [ADDR_W-1:0] STEP_BACK = ADDR_W'(SEQ_STEP);
   localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] CLR_B0    = ~ADDR_W'(1);
   localparam logic [ADDR_W-1:0] CLR_B01   = ~ADDR_W'(3);

   if (ADDR_W < MIN_ADDR_W) begin : g_width_bad
      $error("hw16_branch_unit: ADDR_W must be at least %0d", MIN_ADDR_W);
   end

   br_kind_e          kind;
   logic [3:0]        cond_code;
   logic              src_is_pc;
   logic              cond_hold;
   logic [ADDR_W-1:0] off_short, off_jump, off_call_hi, off_call_lo;
   logic [ADDR_W-1:0] seq_pc, target, exch_tgt;
   logic              decide;
   logic              flush_q;

   hw16_br_decode u_dec (
      .opcode    (opcode),
      .kind      (kind),
      .cond_code (cond_code),
      .src_is_pc (src_is_pc)
   );

   hw16_br_cond u_cond (
      .flags     (flags_t'(flags)),
      .cond_code (cond_code),
      .hold      (cond_hold)
   );

   hw16_br_offsets #(.ADDR_W(ADDR_W)) u_off (
      .opcode      (opcode),
      .off_short   (off_short),
      .off_jump    (off_jump),
      .off_call_hi (off_call_hi),
      .off_call_lo (off_call_lo)
   );

   assign seq_pc   = pc_in - STEP_BACK;
   assign exch_tgt = op_val & (src_is_pc ? CLR_B01 : CLR_B0);

   always_comb begin
      decide = 1'b0;
      target = seq_pc;
      unique case (kind)
         BK_COND: begin
            decide = cond_hold;
            target = pc_in + off_short;
         end
         BK_JUMP: begin
            decide = 1'b1;
            target = pc_in + off_jump;
         end
         BK_CALL_LO: begin
            decide = 1'b1;
            target = lr_in + off_call_lo;
         end
         BK_EXCH: begin
            decide = 1'b1;
            target = exch_tgt;
         end
         default: ;
      endcase
   end

   always_comb begin
      next_lr = lr_in;
      if (kind == BK_CALL_HI)      next_lr = pc_in + off_call_hi;
      else if (kind == BK_CALL_LO) next_lr = pc_in - ONE;
   end

   assign taken       = exec_en & decide;
   assign next_pc     = taken ? target : seq_pc;
   assign narrow_mode = (kind == BK_EXCH) ? op_val[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flush_q <= 1'b0;
      else        flush_q <= taken;
   end

   assign flush = flush_q;

endmodule

// File: rtl/hw16_branch_chk.sv
module hw16_branch_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              exec_en,
   input logic [15:0]       opcode,
   input logic [ADDR_W-1:0] pc_in,
   input logic [ADDR_W-1:0] lr_in,
   input logic [ADDR_W-1:0] op_val,
   input logic              taken,
   input logic [ADDR_W-1:0] next_pc,
   input logic [ADDR_W-1:0] next_lr,
   input logic              narrow_mode,
   input logic              flush
);

   logic is_exch, is_call_lo, is_call_hi;
   assign is_exch    = (opcode[15:7] == 9'b010001110);
   assign is_call_lo = (opcode[15:11] == 5'b11111);
   assign is_call_hi = (opcode[15:11] == 5'b11110);

   // R3
   seq_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !taken |-> next_pc == pc_in - ADDR_W'(2));

   // R4
   no_branch_cc14_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode[15:9] == 7'b1101111) |-> (!taken && next_lr == lr_in));

   // R7
   call_lo_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_call_lo && exec_en && !pc_in[0]) |-> (taken && next_lr[0]));

   // R8
   exch_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_exch && exec_en) |-> (taken && !next_pc[0] && narrow_mode == op_val[0]));

   // R9
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !is_exch |-> narrow_mode);

   // R9
   lr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_call_lo && !is_call_hi) |-> next_lr == lr_in);

   // R10
   no_taken_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_en |-> !taken);

   // R10
   flush_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
      taken |=> flush);

   // R10
   flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!taken && rst_n) |=> !flush);

endmodule

bind hw16_branch_unit hw16_branch_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .exec_en     (exec_en),
   .opcode      (opcode),
   .pc_in       (pc_in),
   .lr_in       (lr_in),
   .op_val      (op_val),
   .taken       (taken),
   .next_pc     (next_pc),
   .next_lr     (next_lr),
   .narrow_mode (narrow_mode),
   .flush       (flush)
);

// File: tb/hw16_branch_unit_test.sv
module hw16_branch_unit_test;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n;
   logic        exec_en;
   logic [15:0] opcode;
   logic [31:0] pc_in, lr_in, op_val;
   logic [3:0]  flags;

   logic        taken, narrow_mode, flush;
   logic [31:0] next_pc, next_lr;
   logic        m_taken, m_mode, m_flush;
   logic [23:0] m_pc, m_lr;

   hw16_branch_unit #(.ADDR_W(32)) uut (
      .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .opcode(opcode),
      .pc_in(pc_in), .lr_in(lr_in), .op_val(op_val), .flags(flags),
      .taken(taken), .next_pc(next_pc), .next_lr(next_lr),
      .narrow_mode(narrow_mode), .flush(flush)
   );

   hw16_branch_unit #(.ADDR_W(24)) uut_min (
      .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .opcode(opcode),
      .pc_in(pc_in[23:0]), .lr_in(lr_in[23:0]), .op_val(op_val[23:0]), .flags(flags),
      .taken(m_taken), .next_pc(m_pc), .next_lr(m_lr),
      .narrow_mode(m_mode), .flush(m_flush)
   );

   int  checks = 0;
   int  fails  = 0;
   bit  prev_t = 1'b0;
   bit  done   = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic bit cond_ok(input logic [3:0] c, input logic [3:0] f);
      bit n = f[3], z = f[2], cy = f[1], v = f[0];
      case (c)
         4'd0:  return z;
         4'd1:  return !z;
         4'd2:  return cy;
         4'd3:  return !cy;
         4'd4:  return n;
         4'd5:  return !n;
         4'd6:  return v;
         4'd7:  return !v;
         4'd8:  return cy && !z;
         4'd9:  return !cy || z;
         4'd10: return n == v;
         4'd11: return n != v;
         4'd12: return !z && (n == v);
         4'd13: return z || (n != v);
         default: return 1'b0;
      endcase
   endfunction

   task automatic apply(input logic [15:0] op, input logic [31:0] pc, input logic [31:0] lr,
                        input logic [31:0] val, input logic [3:0] f, input bit en);
      bit          et, em;
      logic [31:0] npc, nlr, tgt;
      string       tag;
      et = 1'b0; em = 1'b1; nlr = lr; tgt = pc - 32'd2; tag = "R9";
      if (op[15:12] == 4'hD) begin
         if (op[11:8] >= 4'hE) tag = "R4";
         else if (cond_ok(op[11:8], f)) begin
            tag = "R1 R2"; et = en;
            tgt = pc + {{23{op[7]}}, op[7:0], 1'b0};
         end else tag = "R3 R2";
      end else if (op[15:11] == 5'b11100) begin
         tag = "R5"; et = en; tgt = pc + {{20{op[10]}}, op[10:0], 1'b0};
      end else if (op[15:11] == 5'b11110) begin
         tag = "R6"; nlr = pc + {{9{op[10]}}, op[10:0], 12'b0};
      end else if (op[15:11] == 5'b11111) begin
         tag = "R7"; et = en; tgt = lr + {20'b0, op[10:0], 1'b0}; nlr = pc - 32'd1;
      end else if (op[15:7] == 9'h08E) begin
         tag = "R8"; et = en; em = val[0];
         tgt = val & ~32'h1;
         if (op[6:3] == 4'hF) tgt = tgt & ~32'h2;
      end
      if (!en) tag = {tag, " R10"};
      npc = et ? tgt : pc - 32'd2;

      @(negedge clk);
      chk(flush == prev_t, "R10", "flush", 32'(flush), 32'(prev_t));
      chk(m_flush == prev_t, "R10", "flush narrow", 32'(m_flush), 32'(prev_t));
      opcode = op; pc_in = pc; lr_in = lr; op_val = val; flags = f; exec_en = en;
      #2;
      chk(taken == et, tag, "taken", 32'(taken), 32'(et));
      chk(next_pc == npc, tag, "next_pc", next_pc, npc);
      chk(next_lr == nlr, tag, "next_lr", next_lr, nlr);
      chk(narrow_mode == em, tag, "mode", 32'(narrow_mode), 32'(em));
      chk(m_pc == npc[23:0], tag, "next_pc narrow", 32'(m_pc), 32'(npc[23:0]));
      chk(m_lr == nlr[23:0], tag, "next_lr narrow", 32'(m_lr), 32'(nlr[23:0]));
      prev_t = et;
   endtask

   initial begin
      int unsigned seed_v;
      seed_v = $urandom(32'd20240611);
      rst_n = 1'b0; exec_en = 1'b0; opcode = 16'h0000;
      pc_in = 32'h100; lr_in = 32'h0; op_val = 32'h0; flags = 4'h0;
      repeat (3) @(negedge clk);
      // R11: flush held low in reset
      chk(flush == 1'b0, "R11", "flush in reset", 32'(flush), 32'h0);
      chk(m_flush == 1'b0, "R11", "flush in reset narrow", 32'(m_flush), 32'h0);
      rst_n = 1'b1;

      // directed corners
      apply(16'hD080, 32'h0000_1000, 32'h0, 32'h0, 4'b0100, 1'b1); // EQ taken, offset -128
      apply(16'hD17F, 32'h0000_1000, 32'h0, 32'h0, 4'b0100, 1'b1); // NE not taken
      apply(16'hDE12, 32'h0000_2000, 32'h55, 32'h0, 4'b1111, 1'b1); // code 14
      apply(16'hDF12, 32'h0000_2000, 32'h55, 32'h0, 4'b0000, 1'b1); // code 15
      apply(16'hE400, 32'h0000_0004, 32'h0, 32'h0, 4'h0, 1'b1);     // jump, most negative, wraps
      apply(16'hE3FF, 32'hFFFF_FFF0, 32'h0, 32'h0, 4'h0, 1'b1);     // jump wraps upward
      apply(16'hF7FF, 32'h0000_8004, 32'h1, 32'h0, 4'h0, 1'b1);     // call hi negative
      apply(16'hFFFF, 32'h0000_8006, 32'h0000_7004, 32'h0, 4'h0, 1'b1); // call lo
      apply(16'h4778, 32'h0000_3000, 32'h0, 32'h0000_3007, 4'h0, 1'b1); // exchange from PC
      apply(16'h4718, 32'h0000_3000, 32'h0, 32'h0000_4002, 4'h0, 1'b1); // exchange to wide
      apply(16'hE010, 32'h0000_3000, 32'h0, 32'h0, 4'h0, 1'b0);     // not executing
      apply(16'hE010, 32'h0000_3000, 32'h0, 32'h0, 4'h0, 1'b1);     // back-to-back taken
      apply(16'hE010, 32'h0000_3000, 32'h0, 32'h0, 4'h0, 1'b1);
      apply(16'h1234, 32'h0000_0000, 32'h9, 32'h3, 4'hF, 1'b1);     // other opcode at zero
      for (int c = 0; c < 14; c++) begin
         for (int fl = 0; fl < 16; fl++) begin
            apply({4'hD, 4'(c), 8'h22}, 32'h0000_0800, 32'h0, 32'h0, 4'(fl), 1'b1);
         end
      end

      // constrained random
      for (int i = 0; i < 1500; i++) begin
         logic [15:0] op;
         int unsigned sel;
         sel = $urandom % 8;
         op  = 16'($urandom);
         case (sel)
            0, 1: op[15:12] = 4'hD;
            2:    op[15:11] = 5'b11100;
            3:    op[15:11] = 5'b11110;
            4:    op[15:11] = 5'b11111;
            5:    op[15:7]  = 9'h08E;
            6:    op[15:12] = 4'($urandom % 4);
            default: begin op[15:12] = 4'hD; op[11:9] = 3'b111; end
         endcase
         apply(op, {$urandom, 1'b0} >> 1 & ~32'h1, $urandom, $urandom, 4'($urandom),
               ($urandom % 8) != 0);
      end
      apply(16'h0000, 32'h100, 32'h0, 32'h0, 4'h0, 1'b0);
      apply(16'h0000, 32'h100, 32'h0, 32'h0, 4'h0, 1'b0);

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule